// File: doc/BRIEF.md
# Serial ADC Conversion Controller

This block is the host end of a three-wire link to a serial analog-to-digital converter. It drives the converter's conversion-strobe and serial-clock lines and samples the converter's serial data line. Each level of either output line is held for a fixed number of system clocks, and this sets the serial clock rate. A start request raises the strobe for one phase. The block then sends a run of serial clock pulses and shifts in a 13-bit frame. The frame is a reference-settled flag followed by a 12-bit result, most significant bit first. At the end it presents the result with a one-cycle strobe and latches the flag.

The same two lines also put the converter into its low-power states. Strobe pulses sent while the serial clock stays low select light or deep power-down: two pulses give the light state and four give the deep state. A single serial clock pulse wakes the converter. After a wake from light power-down the block stays busy for a settling delay. After a wake from deep power-down it does not trust results until a frame reports the reference settled, or until a timeout runs out. A shutdown level is passed straight through to the converter.

Top module: `adc_link_ctrl`

## Requirements
- R1: A request is taken only when `busy` is low and exactly one of the four request inputs is high. Requests with two or more bits set, and all requests while `busy` is high, have no effect on any output. `busy` goes high in the cycle after a request is taken and stays high until the operation ends.
- R2: Every level driven on `adc_clk` and `adc_conv` lasts exactly CLK_DIV system clocks (one phase). The two lines are never high together, and both are low whenever `busy` is low.
- R3: A conversion is one phase with `adc_conv` high, followed by 14+L serial clock pulses. Each pulse is a high phase and then a low phase. L is the value of `extra_lat` when the start request is taken.
- R4: `adc_dout` is sampled in the system cycle that raises `adc_clk`. The first 1+L samples are thrown away. The next 13 samples, in order, are the reference flag and then result bits 11 down to 0.
- R5: When a conversion ends, `result_valid` pulses for one cycle, in the same cycle that `busy` falls, and `result` carries the 12-bit word. `result` changes only when `result_valid` is high.
- R6: `ref_ready` takes the captured flag at the end of every conversion, and holds its value at all other times.
- R7: A nap request keeps `adc_clk` low and drives `adc_conv` high, low, high, low (two pulses, four phases). The converter is then treated as napping.
- R8: A sleep request keeps `adc_clk` low and sends four `adc_conv` pulses (eight phases). The converter is then treated as sleeping.
- R9: While the converter is napping or sleeping, start, nap and sleep requests are ignored. While it is active, a wake request is ignored.
- R10: A wake request sends one `adc_clk` pulse (a high phase, then a low phase) with `adc_conv` low, and the converter is then active again. After a wake from nap, `busy` stays high for NAP_WAIT_CYC more cycles.
- R11: After a wake from sleep, a conversion whose flag is 0 gives no `result_valid` and leaves `result` unchanged. This lasts until a conversion captures a flag of 1, or until REF_TMO_CYC cycles have passed since `busy` fell at the end of the wake. After that, every conversion is valid.
- R12: `adc_shdn_n` follows `shdn_n_in` with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request a conversion |
| req_nap | input | 1 | Request light power-down |
| req_sleep | input | 1 | Request deep power-down |
| req_wake | input | 1 | Request wake-up |
| extra_lat | input | 1 | Add one serial clock of output latency to the next conversion |
| shdn_n_in | input | 1 | Shutdown level to pass through |
| adc_dout | input | 1 | Serial data from the converter |
| adc_clk | output | 1 | Serial clock to the converter |
| adc_conv | output | 1 | Conversion strobe to the converter |
| adc_shdn_n | output | 1 | Shutdown level to the converter |
| busy | output | 1 | An operation is in progress |
| result | output | 12 | Last valid conversion result |
| result_valid | output | 1 | One-cycle strobe for a new result |
| ref_ready | output | 1 | Reference flag from the last conversion |

## Verification
The hardest case to reach is the gate on results after a wake from deep power-down. It needs a sleep, then a wake, then conversions whose flag is 0, both before and after the timeout. The bench builds the timeout for a few hundred cycles. A model of the converter in the bench serves chosen frames on the serial line. The bench converts right after the wake with the flag clear and then with it set, and it idles past the timeout before a second flag-clear conversion. The latency offset and a request injected in the middle of a conversion are covered the same way, with the pin levels compared on every cycle.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CONV,
        S_PDN,
        S_WAKE,
        S_HOLD
    } seq_t;

    typedef enum logic [1:0] {
        PW_ON,
        PW_NAP,
        PW_SLEEP
    } pw_t;

endpackage

// File: rtl/adc_phase_tick.sv
module adc_phase_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart || cnt_q == CNT_W'(DIV - 1)) cnt_d = '0;
        else                                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == CNT_W'(DIV - 1));
endmodule

// File: rtl/adc_frame_sreg.sv
module adc_frame_sreg #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_en) sh_d = {sh_q[W-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign word = sh_q;
endmodule

// File: rtl/adc_link_ctrl.sv
module adc_link_ctrl
    import adc_link_pkg::*;
#(
    parameter int CLK_DIV      = 4,
    parameter int NAP_WAIT_CYC = 70,
    parameter int REF_TMO_CYC  = 600000,
    parameter int DATA_W       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_nap,
    input  logic              req_sleep,
    input  logic              req_wake,
    input  logic              extra_lat,
    input  logic              shdn_n_in,
    input  logic              adc_dout,
    output logic              adc_clk,
    output logic              adc_conv,
    output logic              adc_shdn_n,
    output logic              busy,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              ref_ready
);
    localparam int FRAME_W = DATA_W + 1;
    localparam int LAST0   = 2 * (FRAME_W + 1);
    localparam int LAST1   = LAST0 + 2;
    localparam int PH_W    = $clog2(LAST1 + 1);
    localparam int WAIT_W  = $clog2(NAP_WAIT_CYC + 1);
    localparam int TMO_W   = $clog2(REF_TMO_CYC + 1);

    typedef struct packed {
        seq_t              st;
        pw_t               pw;
        pw_t               pw_tgt;
        logic              lat;
        logic [PH_W-1:0]   ph;
        logic [PH_W-1:0]   ph_last;
        logic [WAIT_W-1:0] hold;
        logic              refwait;
        logic [TMO_W-1:0]  tmo;
        logic              sclk;
        logic              conv;
        logic              valid;
        logic              rdy;
        logic [DATA_W-1:0] res;
    } ctl_t;

    ctl_t q, d;
    logic tick, restart, shift_en, one_req;
    logic [FRAME_W-1:0] word;
    logic [PH_W-1:0]    skip;

    adc_phase_tick #(.DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
    );

    adc_frame_sreg #(.W(FRAME_W)) u_sreg (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(adc_dout), .word(word)
    );

    assign one_req = $onehot({req_start, req_nap, req_sleep, req_wake});
    assign skip    = q.lat ? PH_W'(4) : PH_W'(2);

    always_comb begin
        d        = q;
        d.valid  = 1'b0;
        restart  = 1'b0;
        shift_en = 1'b0;

        if (q.refwait) begin
            if (q.tmo == TMO_W'(REF_TMO_CYC - 1)) d.refwait = 1'b0;
            else                                  d.tmo     = q.tmo + 1'b1;
        end

        case (q.st)
            S_IDLE: begin
                if (one_req) begin
                    if (req_start && q.pw == PW_ON) begin
                        d.st      = S_CONV;
                        d.lat     = extra_lat;
                        d.ph_last = extra_lat ? PH_W'(LAST1) : PH_W'(LAST0);
                        restart   = 1'b1;
                    end else if (req_nap && q.pw == PW_ON) begin
                        d.st      = S_PDN;
                        d.pw_tgt  = PW_NAP;
                        d.ph_last = PH_W'(3);
                        restart   = 1'b1;
                    end else if (req_sleep && q.pw == PW_ON) begin
                        d.st      = S_PDN;
                        d.pw_tgt  = PW_SLEEP;
                        d.ph_last = PH_W'(7);
                        restart   = 1'b1;
                    end else if (req_wake && q.pw != PW_ON) begin
                        d.st      = S_WAKE;
                        d.ph_last = PH_W'(1);
                        restart   = 1'b1;
                    end
                    d.ph = '0;
                end
            end
            S_CONV, S_PDN, S_WAKE: begin
                if (tick) begin
                    if (q.ph == q.ph_last) begin
                        d.ph = '0;
                        d.st = S_IDLE;
                        if (q.st == S_CONV) begin
                            d.rdy = word[FRAME_W-1];
                            if (!q.refwait || word[FRAME_W-1]) begin
                                d.valid   = 1'b1;
                                d.res     = word[DATA_W-1:0];
                                d.refwait = 1'b0;
                            end
                        end else if (q.st == S_PDN) begin
                            d.pw = q.pw_tgt;
                        end else begin
                            d.pw = PW_ON;
                            if (q.pw == PW_NAP) begin
                                d.st   = S_HOLD;
                                d.hold = '0;
                            end else begin
                                d.refwait = 1'b1;
                                d.tmo     = '0;
                            end
                        end
                    end else begin
                        d.ph = q.ph + 1'b1;
                        if (q.st == S_CONV && !q.ph[0] && q.ph >= skip) shift_en = 1'b1;
                    end
                end
            end
            S_HOLD: begin
                if (q.hold == WAIT_W'(NAP_WAIT_CYC - 1)) d.st   = S_IDLE;
                else                                     d.hold = q.hold + 1'b1;
            end
            default: d.st = S_IDLE;
        endcase

        d.sclk = (d.st == S_CONV && d.ph[0]) || (d.st == S_WAKE && d.ph == '0);
        d.conv = (d.st == S_CONV && d.ph == '0) || (d.st == S_PDN && !d.ph[0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= S_IDLE;
            q.pw     <= PW_ON;
            q.pw_tgt <= PW_ON;
        end else begin
            q <= d;
        end
    end

    assign adc_clk      = q.sclk;
    assign adc_conv     = q.conv;
    assign adc_shdn_n   = shdn_n_in;
    assign busy         = (q.st != S_IDLE);
    assign result       = q.res;
    assign result_valid = q.valid;
    assign ref_ready    = q.rdy;
endmodule

// File: rtl/adc_link_chk.sv
module adc_link_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adc_clk,
    input logic              adc_conv,
    input logic              busy,
    input logic [DATA_W-1:0] result,
    input logic              result_valid,
    input logic              ref_ready
);
    assert_lines_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_conv && adc_clk));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!adc_conv && !adc_clk));

    assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    assert_valid_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $fell(busy));

    assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> result_valid);

    assert_ready_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_ready) |-> $fell(busy));
endmodule

bind adc_link_ctrl adc_link_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .adc_clk(adc_clk), .adc_conv(adc_conv),
    .busy(busy), .result(result), .result_valid(result_valid), .ref_ready(ref_ready)
);

// File: tb/adc_link_ctrl_bench.sv
module adc_link_ctrl_bench;
    localparam int DIV  = 2;
    localparam int NAPW = 6;
    localparam int TMO  = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic rs = 0, rn = 0, rsl = 0, rw = 0, xlat = 0, shdn_in = 1;
    logic dout = 1'b0;
    logic sclk, conv, pdn, busy, vld, rdy;
    logic [11:0] res;

    adc_link_ctrl #(.CLK_DIV(DIV), .NAP_WAIT_CYC(NAPW), .REF_TMO_CYC(TMO), .DATA_W(12)) u_adc_link_ctrl (
        .clk(clk), .rst_n(rst_n), .req_start(rs), .req_nap(rn), .req_sleep(rsl), .req_wake(rw),
        .extra_lat(xlat), .shdn_n_in(shdn_in), .adc_dout(dout), .adc_clk(sclk), .adc_conv(conv),
        .adc_shdn_n(pdn), .busy(busy), .result(res), .result_valid(vld), .ref_ready(rdy)
    );

    int total = 0, bad = 0;
    longint cyc = 0;
    bit done = 0;
    always @(posedge clk) cyc++;

    // converter model: new bit after each rising serial clock
    logic [12:0] dev_frame = '0;
    int dev_lat = 0, dev_n = 0, dev_m = 0;
    always @(posedge conv) dev_n = 0;
    always @(posedge sclk) begin
        dev_n++;
        dev_m = dev_n - 1 - dev_lat;
        dout = (dev_m >= 0 && dev_m < 13) ? dev_frame[12 - dev_m] : 1'b0;
    end

    // reference model state
    bit m_refwait = 0;
    longint m_wait_from = 0;
    logic [11:0] m_res = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic set_req(input int kind, input logic v);
        case (kind)
            0: rs = v;
            1: rn = v;
            2: rsl = v;
            default: rw = v;
        endcase
    endtask

    function automatic int op_len(input int kind, input int lat, input bit nap_wake);
        int nph;
        case (kind)
            0: nph = 29 + 2 * lat;
            1: nph = 4;
            2: nph = 8;
            default: nph = 2;
        endcase
        return nph * DIV + ((kind == 3 && nap_wake) ? NAPW : 0);
    endfunction

    function automatic logic [2:0] exp_pins(input int kind, input int k, input int lat, input bit nap_wake);
        int ph, nph;
        logic b, c, s;
        ph = k / DIV;
        b = 0; c = 0; s = 0;
        case (kind)
            0: nph = 29 + 2 * lat;
            1: nph = 4;
            2: nph = 8;
            default: nph = 2;
        endcase
        if (ph < nph) begin
            b = 1;
            case (kind)
                0: begin c = (ph == 0); s = (ph % 2 == 1); end
                1, 2: c = (ph % 2 == 0);
                default: s = (ph == 0);
            endcase
        end else if (k < op_len(kind, lat, nap_wake)) begin
            b = 1;
        end
        return {b, c, s};
    endfunction

    task automatic run_op(input int kind, input int lat, input bit nap_wake, input string tag, input int inj_k);
        int len;
        logic [2:0] e;
        len = op_len(kind, lat, nap_wake);
        @(negedge clk);
        xlat = lat[0];
        set_req(kind, 1'b1);
        @(negedge clk);
        set_req(kind, 1'b0);
        for (int k = 0; k <= len; k++) begin
            e = exp_pins(kind, k, lat, nap_wake);
            chk({busy, conv, sclk} === e, tag, int'({busy, conv, sclk}), int'(e));
            if (k < len) chk(vld === 1'b0, {tag, " no early valid R5"}, int'(vld), 0);
            if (k == inj_k) rn = 1'b1;
            else if (k == inj_k + 1) rn = 1'b0;
            if (k < len) @(negedge clk);
        end
    endtask

    task automatic convert(input logic [12:0] fr, input int lat, input string tag, input int inj);
        bit ok;
        dev_frame = fr;
        dev_lat = lat;
        ok = !(m_refwait && (cyc - m_wait_from) < TMO) || fr[12];
        run_op(0, lat, 0, tag, inj);
        chk(vld === ok, {tag, " valid R5 R11"}, int'(vld), int'(ok));
        if (ok) begin
            m_res = fr[11:0];
            m_refwait = 0;
        end
        chk(res === m_res, {tag, " result R4 R5"}, int'(res), int'(m_res));
        chk(rdy === fr[12], {tag, " flag R6"}, int'(rdy), int'(fr[12]));
        @(negedge clk);
        chk(vld === 1'b0, {tag, " pulse R5"}, int'(vld), 0);
        chk(res === m_res, {tag, " result hold R5"}, int'(res), int'(m_res));
    endtask

    task automatic ignored(input logic [3:0] v, input string tag);
        @(negedge clk);
        {rs, rn, rsl, rw} = v;
        @(negedge clk);
        {rs, rn, rsl, rw} = 4'b0;
        repeat (6) begin
            chk({busy, conv, sclk, vld} === 4'b0, tag, int'({busy, conv, sclk, vld}), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=%0d exp=0", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, conv, sclk, vld, rdy} === 5'b0, "reset pins R2", int'({busy, conv, sclk, vld, rdy}), 0);
        chk(res === 12'h000, "reset result R5", int'(res), 0);

        shdn_in = 1'b0; #1;
        chk(pdn === 1'b0, "shutdown low R12", int'(pdn), 0);
        shdn_in = 1'b1; #1;
        chk(pdn === 1'b1, "shutdown high R12", int'(pdn), 1);

        convert({1'b1, 12'hABC}, 0, "conv lat0 R3", -10);
        convert({1'b0, 12'h5A3}, 1, "conv lat1 R3 R4", -10);
        convert({1'b1, 12'h801}, 0, "conv with busy nap R1", 5);

        ignored(4'b1100, "multi-hot ignored R1");
        ignored(4'b0001, "wake while active R9");

        run_op(1, 0, 0, "nap pulses R7", -10);
        ignored(4'b1000, "start while napping R9");
        ignored(4'b0010, "sleep while napping R9");
        run_op(3, 0, 1, "wake from nap R10", -10);
        convert({1'b1, 12'h3C5}, 0, "conv after nap R10", -10);

        run_op(2, 0, 0, "sleep pulses R8", -10);
        ignored(4'b0100, "nap while sleeping R9");
        run_op(3, 0, 0, "wake from sleep R10", -10);
        m_refwait = 1;
        m_wait_from = cyc;
        convert({1'b0, 12'h111}, 0, "ref not settled R11", -10);
        convert({1'b1, 12'h222}, 1, "ref settled R11", -10);
        convert({1'b0, 12'h333}, 0, "after settle R11", -10);

        run_op(2, 0, 0, "sleep again R8", -10);
        run_op(3, 0, 0, "wake again R10", -10);
        m_refwait = 1;
        m_wait_from = cyc;
        repeat (TMO + 50) @(negedge clk);
        convert({1'b0, 12'hFED}, 0, "timeout expired R11", -10);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule